// File: doc/BRIEF.md
# Four-Point Walsh Transform Engine with Selectable Coefficient Order

This block computes the forward or the inverse discrete Walsh transform of a vector of four signed integers. The forward path is a radix-2 network of adders and subtractors with no multipliers. Its coefficients leave the block in one of three orders, picked by a two-bit select: natural (Hadamard), dyadic (Paley, bit-reversed index) or sequency (rows ranked by how many sign changes they have).

The inverse path takes a coefficient vector given in the selected order and puts it back into natural order. It runs it through the same add/subtract network and then divides each sum by four with an arithmetic right shift. The result is a vector of time-domain samples in index order.

A one-cycle `start` loads the inputs. The result is registered, and `done` pulses for one cycle two clock edges after `start` was sampled. The engine is a two-stage pipeline, so `start` may be raised on consecutive cycles. The output holds its last value between results.

Top module: `wht4_engine`

## Requirements
- R1: With `order_sel` = 2'b00 and `inverse` = 0, output slot k carries the natural coefficient h[k] = sum over i of s(k,i)*x[i]. Here s(k,i) is -1 when k AND i has an odd number of set bits and +1 otherwise. For example, {-6,-2,3,7} gives {2,-8,-18,0}, and {6,6,5,-5} gives {12,10,12,-10}.
- R2: With `order_sel` = 2'b01, the forward output is in dyadic order: slot k holds h[bitrev2(k)], which is {h0,h2,h1,h3}.
- R3: With `order_sel` = 2'b10, the forward output is in sequency order: slot k holds the row with k sign changes, which is {h0,h2,h3,h1}.
- R4: `order_sel` = 2'b11 behaves exactly like 2'b00, in both directions.
- R5: With `inverse` = 1, input slot k is read as a coefficient in the order named by `order_sel`. The output is x[i] = floor((sum over rows r of s(r,i)*c[r]) / 4), with rounding toward minus infinity.
- R6: Applying the inverse to a forward result, with the same order select, returns the original vector exactly, as long as the coefficients fit in `IN_W` bits.
- R7: `done` is high in exactly the cycle after the second rising edge that follows a `start` sample, for one cycle per `start`. Back-to-back starts give back-to-back results.
- R8: While `done` is low, `dout` keeps its value, whatever happens on `din`, `order_sel` and `inverse`.
- R9: After reset, `done` is 0 and `dout` is all zeros.
- R10: In forward mode, slot 0 is the sum of the four inputs for every order, and the sum of the four outputs is four times x[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load `din` and the mode inputs into the pipeline |
| order_sel | input | 2 | 00 natural, 01 dyadic, 10 sequency, 11 natural |
| inverse | input | 1 | 0 forward transform, 1 scaled inverse transform |
| din | input | 4 x IN_W | Four signed samples or coefficients; element i is din[i] |
| dout | output | 4 x (IN_W+2) | Four signed results; element k is dout[k] |
| done | output | 1 | One-cycle pulse marking a new result on `dout` |

## Verification
The two vectors with known coefficients pin down the natural row signs. Running the same vectors under each order code then separates the dyadic permutation from the sequency one, and shows that code 11 falls back to natural order. All-minimum, all-maximum and alternating-extreme inputs probe the growth bits at the edges of the range. Single-nonzero coefficients of +1 and -1 on the inverse path show that the division floors rather than truncates. Random full-range vectors in every mode, together with forward-then-inverse round trips, test the whole engine against the bench's sign-product and sign-change-count model. Consecutive starts and idle cycles with changing inputs exercise the pipeline timing and the output hold.

// File: rtl/wht_pkg.sv
package wht_pkg;

  localparam int N     = 4;
  localparam int LOG_N = 2;

  typedef enum logic [1:0] {
    ORD_NATURAL  = 2'b00,
    ORD_DYADIC   = 2'b01,
    ORD_SEQUENCY = 2'b10,
    ORD_ALIAS    = 2'b11
  } order_e;

  // reverse the LOG_N index bits
  function automatic int unsigned bit_rev(input int unsigned k);
    int unsigned r;
    r = 0;
    for (int b = 0; b < LOG_N; b++) begin
      r = (r << 1) | ((k >> b) & 1);
    end
    return r;
  endfunction

  // natural row that lands in output slot `slot` for a given order
  function automatic int unsigned row_of_slot(input order_e ord, input int unsigned slot);
    int unsigned g;
    g = slot ^ (slot >> 1);
    case (ord)
      ORD_DYADIC:   return bit_rev(slot);
      ORD_SEQUENCY: return bit_rev(g);
      default:      return slot;
    endcase
  endfunction

  // output slot that holds natural row `row` for a given order
  function automatic int unsigned slot_of_row(input order_e ord, input int unsigned row);
    int unsigned s;
    s = 0;
    for (int unsigned p = 0; p < N; p++) begin
      if (row_of_slot(ord, p) == row) s = p;
    end
    return s;
  endfunction

endpackage

// File: rtl/wht_bfly_stage.sv
module wht_bfly_stage
  import wht_pkg::*;
#(
  parameter int IN_W = 8,
  parameter int SPAN = 1
) (
  input  logic [N-1:0][IN_W-1:0] a,
  output logic [N-1:0][IN_W:0]   y
);

  function automatic logic [IN_W:0] pair_sum(input logic [IN_W-1:0] p, input logic [IN_W-1:0] q);
    return {p[IN_W-1], p} + {q[IN_W-1], q};
  endfunction

  function automatic logic [IN_W:0] pair_diff(input logic [IN_W-1:0] p, input logic [IN_W-1:0] q);
    return {p[IN_W-1], p} - {q[IN_W-1], q};
  endfunction

  for (genvar g = 0; g < N; g++) begin : g_pair
    if ((g & SPAN) == 0) begin : g_top
      assign y[g]        = pair_sum(a[g], a[g+SPAN]);
      assign y[g + SPAN] = pair_diff(a[g], a[g+SPAN]);
    end
  end

endmodule

// File: rtl/wht_reorder.sv
module wht_reorder
  import wht_pkg::*;
#(
  parameter int W      = 8,
  parameter bit GATHER = 1'b1
) (
  input  order_e              ord,
  input  logic [N-1:0][W-1:0] a,
  output logic [N-1:0][W-1:0] y
);

  for (genvar k = 0; k < N; k++) begin : g_slot
    if (GATHER) begin : g_gather
      // natural order in, selected order out
      always_comb y[k] = a[row_of_slot(ord, k)];
    end else begin : g_scatter
      // selected order in, natural order out
      always_comb y[k] = a[slot_of_row(ord, k)];
    end
  end

endmodule

// File: rtl/wht_scale.sv
module wht_scale
  import wht_pkg::*;
#(
  parameter int W     = 10,
  parameter int SHIFT = 2
) (
  input  logic [N-1:0][W-1:0] a,
  output logic [N-1:0][W-1:0] y
);

  function automatic logic [W-1:0] floor_div(input logic [W-1:0] v);
    return $signed(v) >>> SHIFT;
  endfunction

  for (genvar k = 0; k < N; k++) begin : g_elem
    assign y[k] = floor_div(a[k]);
  end

endmodule

// File: rtl/wht4_engine.sv
module wht4_engine
  import wht_pkg::*;
#(
  parameter int IN_W = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                start,
  input  logic [1:0]                          order_sel,
  input  logic                                inverse,
  input  logic [N-1:0][IN_W-1:0]              din,
  output logic [N-1:0][IN_W+LOG_N-1:0]        dout,
  output logic                                done
);

  localparam int MID_W = IN_W + 1;
  localparam int OUT_W = IN_W + LOG_N;

  order_e                    ord_in;
  logic [N-1:0][IN_W-1:0]    din_nat;
  logic [N-1:0][IN_W-1:0]    front;
  logic [N-1:0][MID_W-1:0]   mid;

  logic [N-1:0][MID_W-1:0]   s1_data;
  logic                      s1_valid;
  logic                      s1_inv;
  order_e                    s1_ord;

  logic [N-1:0][OUT_W-1:0]   nat_res;
  logic [N-1:0][OUT_W-1:0]   fwd_res;
  logic [N-1:0][OUT_W-1:0]   inv_res;
  logic [N-1:0][OUT_W-1:0]   result;
  logic                      out_load;

  assign ord_in = order_e'(order_sel);

  // inverse: restore natural coefficient order before the kernel
  wht_reorder #(.W(IN_W), .GATHER(1'b0)) u_unpermute (
    .ord (ord_in),
    .a   (din),
    .y   (din_nat)
  );

  assign front = inverse ? din_nat : din;

  wht_bfly_stage #(.IN_W(IN_W), .SPAN(1)) u_stage_a (
    .a (front),
    .y (mid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_inv   <= 1'b0;
      s1_ord   <= ORD_NATURAL;
      s1_data  <= '0;
    end else begin
      s1_valid <= start;
      if (start) begin
        s1_inv  <= inverse;
        s1_ord  <= ord_in;
        s1_data <= mid;
      end
    end
  end

  wht_bfly_stage #(.IN_W(MID_W), .SPAN(2)) u_stage_b (
    .a (s1_data),
    .y (nat_res)
  );

  wht_reorder #(.W(OUT_W), .GATHER(1'b1)) u_permute (
    .ord (s1_ord),
    .a   (nat_res),
    .y   (fwd_res)
  );

  wht_scale #(.W(OUT_W), .SHIFT(LOG_N)) u_scale (
    .a (nat_res),
    .y (inv_res)
  );

  assign result   = s1_inv ? inv_res : fwd_res;
  assign out_load = s1_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
      done <= 1'b0;
    end else begin
      done <= out_load;
      if (out_load) dout <= result;
    end
  end

endmodule

// File: rtl/wht4_checker.sv
module wht4_checker
  import wht_pkg::*;
#(
  parameter int IN_W = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         start,
  input logic                         inverse,
  input logic [N-1:0][IN_W-1:0]       din,
  input logic [N-1:0][IN_W+LOG_N-1:0] dout,
  input logic                         done,
  input logic                         s1_valid
);

  localparam int OUT_W = IN_W + LOG_N;

  logic [1:0]             cyc;
  logic [N-1:0][IN_W-1:0] din_d1, din_d2;
  logic                   inv_d1, inv_d2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc    <= '0;
      din_d1 <= '0;
      din_d2 <= '0;
      inv_d1 <= 1'b0;
      inv_d2 <= 1'b0;
    end else begin
      if (cyc != 2'd3) cyc <= cyc + 2'd1;
      din_d1 <= din;
      din_d2 <= din_d1;
      inv_d1 <= inverse;
      inv_d2 <= inv_d1;
    end
  end

  function automatic int sum_in(input logic [N-1:0][IN_W-1:0] v);
    int s;
    s = 0;
    for (int i = 0; i < N; i++) s += int'($signed(v[i]));
    return s;
  endfunction

  function automatic int sum_out(input logic [N-1:0][OUT_W-1:0] v);
    int s;
    s = 0;
    for (int i = 0; i < N; i++) s += int'($signed(v[i]));
    return s;
  endfunction

  // R7: stage one follows the start strobe by one edge
  assert_stage_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd1) |-> (s1_valid == $past(start)));

  // R7: done follows stage one by one edge
  assert_done_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2) |-> (done == $past(s1_valid)));

  // R8: output is held while no result is presented
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd1 && !done) |-> $stable(dout));

  // R10: slot 0 is the DC term for every order
  assert_dc_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd3 && done && !inv_d2) |-> (int'($signed(dout[0])) == sum_in(din_d2)));

  // R10: the coefficients add up to four times the first sample
  assert_coef_sum_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd3 && done && !inv_d2) |-> (sum_out(dout) == 4 * int'($signed(din_d2[0]))));

  // R5: first inverse sample is the floored mean of the coefficients
  assert_inv_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd3 && done && inv_d2) |-> (int'($signed(dout[0])) == (sum_in(din_d2) >>> 2)));

endmodule

bind wht4_engine wht4_checker #(.IN_W(IN_W)) u_wht4_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .inverse  (inverse),
  .din      (din),
  .dout     (dout),
  .done     (done),
  .s1_valid (s1_valid)
);

// File: tb/test_wht4_engine.sv
module test_wht4_engine;

  localparam int IN_W  = 8;
  localparam int OUT_W = IN_W + 2;

  typedef int vec_t[4];

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    start = 1'b0;
  logic                    inverse = 1'b0;
  logic [1:0]              order_sel = 2'b00;
  logic [3:0][IN_W-1:0]    din = '0;
  logic [3:0][OUT_W-1:0]   dout;
  logic                    done;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  wht4_engine #(.IN_W(IN_W)) i_wht4_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .order_sel (order_sel),
    .inverse   (inverse),
    .din       (din),
    .dout      (dout),
    .done      (done)
  );

  // ---------------- reference model ----------------
  function automatic int sgn(int k, int i);
    return ($countones(k & i) % 2 == 1) ? -1 : 1;
  endfunction

  function automatic int row_for_slot(int sel, int p);
    int changes;
    if (sel == 1) return ((p & 1) << 1) | ((p >> 1) & 1);
    if (sel == 2) begin
      for (int r = 0; r < 4; r++) begin
        changes = 0;
        for (int i = 0; i < 3; i++) if (sgn(r, i) != sgn(r, i + 1)) changes++;
        if (changes == p) return r;
      end
    end
    return p;
  endfunction

  function automatic vec_t model_fwd(vec_t x, int sel);
    vec_t y;
    for (int p = 0; p < 4; p++) begin
      y[p] = 0;
      for (int i = 0; i < 4; i++) y[p] += sgn(row_for_slot(sel, p), i) * x[i];
    end
    return y;
  endfunction

  function automatic vec_t model_inv(vec_t c, int sel);
    vec_t nat, x;
    int acc;
    for (int p = 0; p < 4; p++) nat[row_for_slot(sel, p)] = c[p];
    for (int i = 0; i < 4; i++) begin
      acc = 0;
      for (int k = 0; k < 4; k++) acc += sgn(k, i) * nat[k];
      x[i] = acc >>> 2;
    end
    return x;
  endfunction

  // ---------------- checking ----------------
  task automatic check_int(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_out(string tag, vec_t exp);
    for (int k = 0; k < 4; k++)
      check_int(tag, $sformatf("dout[%0d]", k), int'($signed(dout[k])), exp[k]);
  endtask

  function automatic vec_t read_out();
    vec_t v;
    for (int k = 0; k < 4; k++) v[k] = int'($signed(dout[k]));
    return v;
  endfunction

  task automatic drive(vec_t x, int sel, bit inv_m);
    for (int i = 0; i < 4; i++) din[i] = IN_W'(x[i]);
    order_sel = 2'(sel);
    inverse   = inv_m;
    start     = 1'b1;
  endtask

  // one operation; sampled at the falling edge after the second rising edge
  task automatic run_op(string tag, vec_t x, int sel, bit inv_m, vec_t exp);
    @(negedge clk);
    drive(x, sel, inv_m);
    @(negedge clk);
    start = 1'b0;
    check_int("R7", "done one edge after start", int'(done), 0);
    @(negedge clk);
    check_int("R7", "done two edges after start", int'(done), 1);
    check_out(tag, exp);
    @(negedge clk);
    check_int("R7", "done single pulse", int'(done), 0);
  endtask

  function automatic int rnd_range(int lo, int hi);
    return lo + int'($urandom % (hi - lo + 1));
  endfunction

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    vec_t a, b, e, x, c;
    int sel;
    bit im;
    vec_t held;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    // R9: reset state
    check_int("R9", "done in reset", int'(done), 0);
    check_out("R9", '{0, 0, 0, 0});
    rst_n = 1'b1;
    @(negedge clk);
    check_int("R9", "done after reset", int'(done), 0);
    check_out("R9", '{0, 0, 0, 0});

    a = '{-6, -2, 3, 7};
    b = '{6, 6, 5, -5};
    // R1: known natural coefficients
    run_op("R1", a, 0, 1'b0, '{2, -8, -18, 0});
    run_op("R1", b, 0, 1'b0, '{12, 10, 12, -10});
    // R2: dyadic order
    run_op("R2", a, 1, 1'b0, '{2, -18, -8, 0});
    run_op("R2", b, 1, 1'b0, model_fwd(b, 1));
    // R3: sequency order
    run_op("R3", a, 2, 1'b0, '{2, -18, 0, -8});
    run_op("R3", b, 2, 1'b0, '{12, 12, -10, 10});
    // R4: code 11 acts as natural
    run_op("R4", b, 3, 1'b0, '{12, 10, 12, -10});
    run_op("R4", '{12, 10, 12, -10}, 3, 1'b1, b);
    // R5/R6: inverse of known coefficients in several orders
    run_op("R5", '{2, -8, -18, 0}, 0, 1'b1, a);
    run_op("R6", '{2, -18, -8, 0}, 1, 1'b1, a);
    run_op("R6", '{2, -18, 0, -8}, 2, 1'b1, a);
    // R5: floor division
    run_op("R5", '{1, 0, 0, 0}, 0, 1'b1, '{0, 0, 0, 0});
    run_op("R5", '{-1, 0, 0, 0}, 0, 1'b1, '{-1, -1, -1, -1});
    run_op("R5", '{0, 3, 0, 0}, 0, 1'b1, '{0, -1, 0, -1});
    // R1: range extremes
    run_op("R1", '{-128, -128, -128, -128}, 0, 1'b0, '{-512, 0, 0, 0});
    run_op("R1", '{127, 127, 127, 127}, 0, 1'b0, '{508, 0, 0, 0});
    run_op("R1", '{127, -128, 127, -128}, 0, 1'b0, '{-2, 510, 0, 0});
    run_op("R5", '{-128, -128, -128, -128}, 0, 1'b1, '{-128, 0, 0, 0});

    // R7: back-to-back starts
    @(negedge clk);
    drive(a, 0, 1'b0);
    @(negedge clk);
    drive(b, 2, 1'b0);
    @(negedge clk);
    start = 1'b0;
    check_int("R7", "first of pair done", int'(done), 1);
    check_out("R7", model_fwd(a, 0));
    @(negedge clk);
    check_int("R7", "second of pair done", int'(done), 1);
    check_out("R7", model_fwd(b, 2));
    @(negedge clk);
    check_int("R7", "pair then idle", int'(done), 0);

    // R8: no start, changing inputs, output held
    held = read_out();
    for (int n = 0; n < 5; n++) begin
      for (int i = 0; i < 4; i++) din[i] = IN_W'(rnd_range(-128, 127));
      order_sel = 2'(n);
      inverse   = n[0];
      @(negedge clk);
      check_int("R8", "done idle", int'(done), 0);
      check_out("R8", held);
    end

    // random full-range vectors, all modes
    for (int n = 0; n < 160; n++) begin
      for (int i = 0; i < 4; i++) x[i] = rnd_range(-128, 127);
      sel = rnd_range(0, 3);
      im  = 1'($urandom % 2);
      if (im) run_op("R5", x, sel, 1'b1, model_inv(x, sel));
      else if (sel == 0 || sel == 3) run_op("R1", x, sel, 1'b0, model_fwd(x, sel));
      else if (sel == 1) run_op("R2", x, sel, 1'b0, model_fwd(x, sel));
      else run_op("R3", x, sel, 1'b0, model_fwd(x, sel));
    end

    // R6: random round trips with coefficients that fit IN_W bits
    for (int n = 0; n < 40; n++) begin
      for (int i = 0; i < 4; i++) x[i] = rnd_range(-31, 31);
      sel = rnd_range(0, 3);
      run_op("R6", x, sel, 1'b0, model_fwd(x, sel));
      c = read_out();
      run_op("R6", c, sel, 1'b1, x);
    end

    finish_run();
  end

endmodule